// File: doc/BRIEF.md
# Transmitter Emptiness Tracker with Half-Duplex Direction Control

This block follows how empty the transmit path of one serial channel is. It watches the transmit queue occupancy and a busy flag from the serializer, and from them keeps two status flags. The first flag shows that nothing waits in the queue, or in the single holding register when queuing is off. The second flag shows that the queue is empty and the serializer is idle as well. The host reads both flags to find out why a transmit interrupt was raised.

The block raises a latched transmit interrupt request. In the normal mode the request comes from the queue dropping through a programmable threshold or from the queue draining. In half-duplex mode it comes only when the whole transmit path has gone idle. A host write of new data clears the request. So does a read of the interrupt identification while the transmit source is the one reported.

For half-duplex bus transceivers the block drives a driver-enable line. The line switches on at once when there is work to send and stays on until one cycle after the serializer finishes. Its polarity can be selected. A mode bit can put this line onto the shared request-to-send pin, where it takes priority over the receiver's automatic flow-control level.

Top module: `uart_txstat_ctrl`

## Requirements
- R1: While reset is applied and right after it is released, `hold_empty` and `xmit_empty` read 1, `tx_irq` reads 0, and `drv_en` sits at its inactive level (1 when `dir_active_low`=1, else 0).
- R2: `hold_empty` is 1 exactly when `tx_count` was 0 on the previous clock edge, whatever the state of `ser_busy`.
- R3: `xmit_empty` is 1 exactly when, on the previous edge, `tx_count` was 0 and `ser_busy` was 0. Whenever `xmit_empty` is 1, `hold_empty` is 1.
- R4: With `rs485_en`=0, `fifo_en`=1, `irq_en`=1 and `trig_level` nonzero, a change of `tx_count` from above `trig_level` to at most `trig_level` sets `tx_irq` on the next cycle. If the new count is nonzero, both status flags read 0 at that point.
- R5: With `rs485_en`=0 and `irq_en`=1, a change of `tx_count` from nonzero to 0 sets `tx_irq` on the next cycle, while `hold_empty` reads 1.
- R6: With `rs485_en`=1 and `irq_en`=1, `tx_irq` is set only on the cycle after the path goes from not-idle to idle (`tx_count`=0 and `ser_busy`=0). A queue that drains while `ser_busy`=1 does not set it.
- R7: `tx_irq` clears on the cycle after `host_wr`=1, or after `id_rd`=1 with `id_tx_src`=1, or after `irq_en`=0. If a set condition occurs in the same cycle, the set wins. An `id_rd` with `id_tx_src`=0 leaves `tx_irq` unchanged.
- R8: With `rs485_en`=1, `drv_en` is at its active level in the same cycle that `tx_count` is nonzero or `ser_busy`=1. It also stays active for the one cycle after both become idle.
- R9: The active level of `drv_en` is 0 when `dir_active_low`=1 and 1 when it is 0.
- R10: `rts_out` equals `drv_en` when `rs485_en`=1 and `dir_on_rts`=1; in every other case it equals `auto_rts_n`.
- R11: With `rs485_en`=0, `drv_en` stays at its inactive level whatever the occupancy or busy state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_count | input | CW (8) | Transmit queue occupancy |
| ser_busy | input | 1 | Serializer is shifting a character |
| trig_level | input | CW (8) | Transmit threshold; 0 disables threshold events |
| fifo_en | input | 1 | Queuing enabled (else single holding register) |
| rs485_en | input | 1 | Half-duplex direction mode |
| dir_active_low | input | 1 | Driver-enable polarity select |
| dir_on_rts | input | 1 | Route driver-enable onto the request-to-send pin |
| auto_rts_n | input | 1 | Automatic flow-control level from the receiver |
| irq_en | input | 1 | Transmit interrupt enable |
| host_wr | input | 1 | Host writes transmit data |
| id_rd | input | 1 | Host reads interrupt identification |
| id_tx_src | input | 1 | Transmit interrupt is the reported source |
| hold_empty | output | 1 | Queue / holding register empty |
| xmit_empty | output | 1 | Queue and serializer both empty |
| tx_irq | output | 1 | Transmit interrupt request |
| drv_en | output | 1 | Half-duplex driver-enable |
| rts_out | output | 1 | Request-to-send pin level |

## Verification
Several properties are checked on every cycle. Full emptiness always implies holding emptiness, and the holding flag follows the previous occupancy. The driver-enable stays active while work is pending, the shared pin follows the driver-enable in the routed mode, and the interrupt clears after an unmatched acknowledge. In half-duplex mode the interrupt can only rise after a fully idle path. Other behaviour needs the bench's scenarios: the exact cycle of threshold and drain events, set-over-clear in the same cycle, the one-cycle hold of the driver-enable after the last stop bit, polarity at reset, and the interrupt's status signature. The bench compares all outputs against a cycle model under long random traffic.

// File: rtl/txs_pkg.sv
package txs_pkg;
    // Registered emptiness flags
    typedef struct packed {
        logic hold_empty;
        logic xmit_empty;
    } txs_stat_t;
endpackage

// File: rtl/txs_status.sv
module txs_status #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] tx_count,
    input  logic          ser_busy,
    output logic          hold_empty,
    output logic          xmit_empty
);
    import txs_pkg::*;

    txs_stat_t st_d, st_q;

    always_comb begin
        st_d            = st_q;
        st_d.hold_empty = (tx_count == '0);
        st_d.xmit_empty = (tx_count == '0) && !ser_busy;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.hold_empty <= 1'b1;
            st_q.xmit_empty <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign hold_empty = st_q.hold_empty;
    assign xmit_empty = st_q.xmit_empty;

    // R3
    xmit_implies_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xmit_empty |-> hold_empty);

    // R2
    hold_follows_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_count != '0) |=> !hold_empty);
endmodule

// File: rtl/txs_irq.sv
module txs_irq #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] tx_count,
    input  logic          ser_busy,
    input  logic [CW-1:0] trig_level,
    input  logic          fifo_en,
    input  logic          rs485_en,
    input  logic          irq_en,
    input  logic          host_wr,
    input  logic          id_rd,
    input  logic          id_tx_src,
    output logic          tx_irq
);
    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          idle;
        logic          irq;
    } irq_st_t;

    irq_st_t s_d, s_q;
    logic idle_now, drain_evt, thresh_evt, set_evt, clr_evt;

    always_comb begin
        idle_now   = (tx_count == '0) && !ser_busy;
        drain_evt  = (s_q.cnt != '0) && (tx_count == '0);
        thresh_evt = fifo_en && (trig_level != '0) &&
                     (s_q.cnt > trig_level) && (tx_count <= trig_level);
        set_evt    = irq_en && (rs485_en ? (!s_q.idle && idle_now)
                                         : (drain_evt || thresh_evt));
        clr_evt    = host_wr || (id_rd && id_tx_src) || !irq_en;

        s_d      = s_q;
        s_d.cnt  = tx_count;
        s_d.idle = idle_now;
        if (set_evt)      s_d.irq = 1'b1;
        else if (clr_evt) s_d.irq = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.cnt  <= '0;
            s_q.idle <= 1'b1;
            s_q.irq  <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign tx_irq = s_q.irq;

    // R7
    irq_ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_irq && host_wr && !set_evt) |=> !tx_irq);

    // R6
    rs485_irq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rs485_en && !tx_irq && (ser_busy || tx_count != '0)) |=> !tx_irq);
endmodule

// File: rtl/txs_dir.sv
module txs_dir #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] tx_count,
    input  logic          ser_busy,
    input  logic          rs485_en,
    input  logic          dir_active_low,
    input  logic          dir_on_rts,
    input  logic          auto_rts_n,
    output logic          drv_en,
    output logic          rts_out
);
    typedef struct packed {
        logic act;
    } dir_st_t;

    dir_st_t d_d, d_q;
    logic act_now, drive_on;

    always_comb begin
        act_now  = (tx_count != '0) || ser_busy;
        drive_on = rs485_en && (act_now || d_q.act);
        d_d      = d_q;
        d_d.act  = act_now;
        drv_en   = drive_on ^ dir_active_low;
        rts_out  = (rs485_en && dir_on_rts) ? drv_en : auto_rts_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) d_q.act <= 1'b0;
        else        d_q     <= d_d;
    end

    // R8
    drv_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rs485_en && ((tx_count != '0) || ser_busy)) |-> (drv_en == !dir_active_low));

    // R10
    shared_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rs485_en && dir_on_rts) |-> (rts_out == drv_en));

    // R11
    drv_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rs485_en |-> (drv_en == dir_active_low));
endmodule

// File: rtl/uart_txstat_ctrl.sv
module uart_txstat_ctrl #(
    parameter int FIFO_DEPTH = 128,
    localparam int CW = $clog2(FIFO_DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] tx_count,
    input  logic          ser_busy,
    input  logic [CW-1:0] trig_level,
    input  logic          fifo_en,
    input  logic          rs485_en,
    input  logic          dir_active_low,
    input  logic          dir_on_rts,
    input  logic          auto_rts_n,
    input  logic          irq_en,
    input  logic          host_wr,
    input  logic          id_rd,
    input  logic          id_tx_src,
    output logic          hold_empty,
    output logic          xmit_empty,
    output logic          tx_irq,
    output logic          drv_en,
    output logic          rts_out
);
    txs_status #(.CW(CW)) status_i (
        .clk(clk), .rst_n(rst_n), .tx_count(tx_count), .ser_busy(ser_busy),
        .hold_empty(hold_empty), .xmit_empty(xmit_empty)
    );

    txs_irq #(.CW(CW)) irq_i (
        .clk(clk), .rst_n(rst_n), .tx_count(tx_count), .ser_busy(ser_busy),
        .trig_level(trig_level), .fifo_en(fifo_en), .rs485_en(rs485_en),
        .irq_en(irq_en), .host_wr(host_wr), .id_rd(id_rd),
        .id_tx_src(id_tx_src), .tx_irq(tx_irq)
    );

    txs_dir #(.CW(CW)) dir_i (
        .clk(clk), .rst_n(rst_n), .tx_count(tx_count), .ser_busy(ser_busy),
        .rs485_en(rs485_en), .dir_active_low(dir_active_low),
        .dir_on_rts(dir_on_rts), .auto_rts_n(auto_rts_n),
        .drv_en(drv_en), .rts_out(rts_out)
    );
endmodule

// File: tb/uart_txstat_ctrl_tb_top.sv
module uart_txstat_ctrl_tb_top;
    localparam int CW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [CW-1:0] tx_count = '0, trig_level = '0;
    logic ser_busy = 0, fifo_en = 1, rs485_en = 0, dir_active_low = 1, dir_on_rts = 0;
    logic auto_rts_n = 1, irq_en = 1, host_wr = 0, id_rd = 0, id_tx_src = 0;
    logic hold_empty, xmit_empty, tx_irq, drv_en, rts_out;

    int checks = 0, failures = 0;
    bit done = 0;

    // bench model state
    logic [CW-1:0] m_cnt = '0;
    logic m_idle = 1, m_act = 0, m_irq = 0, m_hold = 1, m_xmit = 1;

    always #10 clk = ~clk;

    uart_txstat_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .tx_count(tx_count), .ser_busy(ser_busy),
        .trig_level(trig_level), .fifo_en(fifo_en), .rs485_en(rs485_en),
        .dir_active_low(dir_active_low), .dir_on_rts(dir_on_rts),
        .auto_rts_n(auto_rts_n), .irq_en(irq_en), .host_wr(host_wr),
        .id_rd(id_rd), .id_tx_src(id_tx_src), .hold_empty(hold_empty),
        .xmit_empty(xmit_empty), .tx_irq(tx_irq), .drv_en(drv_en), .rts_out(rts_out)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0b expected=%0b t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic logic exp_drv();
        logic on = rs485_en && ((tx_count != '0) || ser_busy || m_act);
        return on ^ dir_active_low;
    endfunction

    function automatic logic exp_rts();
        return (rs485_en && dir_on_rts) ? exp_drv() : auto_rts_n;
    endfunction

    function automatic logic next_irq();
        logic idle_now = (tx_count == '0) && !ser_busy;
        logic drain = (m_cnt != '0) && (tx_count == '0);
        logic thr = fifo_en && (trig_level != '0) && (m_cnt > trig_level) && (tx_count <= trig_level);
        logic set = irq_en && (rs485_en ? (!m_idle && idle_now) : (drain || thr));
        logic clr = host_wr || (id_rd && id_tx_src) || !irq_en;
        return set ? 1'b1 : (clr ? 1'b0 : m_irq);
    endfunction

    // inputs set just after a negedge; returns at the following negedge
    task automatic tick();
        #2;
        check("R8 drv", drv_en, exp_drv());
        check("R10 rts", rts_out, exp_rts());
        @(posedge clk);
        m_irq  = next_irq();
        m_hold = (tx_count == '0);
        m_xmit = (tx_count == '0) && !ser_busy;
        m_idle = m_xmit;
        m_act  = (tx_count != '0) || ser_busy;
        m_cnt  = tx_count;
        @(negedge clk);
        check("R2 hold", hold_empty, m_hold);
        check("R3 xmit", xmit_empty, m_xmit);
        check("R4 irq", tx_irq, m_irq);
    endtask

    task automatic quiet();
        host_wr = 0; id_rd = 0; id_tx_src = 0;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd5813));
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 hold", hold_empty, 1'b1);
        check("R1 xmit", xmit_empty, 1'b1);
        check("R1 irq", tx_irq, 1'b0);
        check("R1 drv", drv_en, 1'b1);
        rst_n = 1;
        @(negedge clk);
        check("R1 hold post", hold_empty, 1'b1);

        // R5 drain event, serializer still busy
        dir_active_low = 0; fifo_en = 1; trig_level = 0;
        tx_count = 3; ser_busy = 1; tick();
        tx_count = 0; tick();
        check("R5 irq", tx_irq, 1'b1);
        check("R5 hold", hold_empty, 1'b1);
        check("R5 xmit", xmit_empty, 1'b0);
        // R7 unmatched id read keeps, matched clears
        id_rd = 1; id_tx_src = 0; tick();
        check("R7 keep", tx_irq, 1'b1);
        id_tx_src = 1; tick(); quiet();
        check("R7 idclr", tx_irq, 1'b0);

        // R4 threshold event
        trig_level = 4; tx_count = 6; tick();
        tx_count = 4; tick();
        check("R4 irq", tx_irq, 1'b1);
        check("R4 hold0", hold_empty, 1'b0);
        check("R4 xmit0", xmit_empty, 1'b0);
        // R7 set wins over write in same cycle
        tx_count = 0; host_wr = 1; tick();
        check("R7 setwins", tx_irq, 1'b1);
        host_wr = 1; tick(); quiet();
        check("R7 wrclr", tx_irq, 1'b0);

        // R6 half-duplex: drain while busy does not set
        rs485_en = 1; tx_count = 2; ser_busy = 1; tick();
        tx_count = 0; tick();
        check("R6 noirq", tx_irq, 1'b0);
        // R8 driver held during busy, then one extra cycle
        #2 check("R8 busy", drv_en, 1'b1);
        ser_busy = 0;
        #1 check("R8 hold1", drv_en, 1'b1);
        tick();
        check("R6 irq", tx_irq, 1'b1);
        #2 check("R8 off", drv_en, 1'b0);
        tick();
        // R9 polarity
        dir_active_low = 1; ser_busy = 1;
        #2 check("R9 lowact", drv_en, 1'b0);
        // R10 shared pin
        dir_on_rts = 1; auto_rts_n = 1;
        #1 check("R10 share", rts_out, 1'b0);
        tick();
        // R11 mode off
        rs485_en = 0; tx_count = 5;
        #2 check("R11 idle", drv_en, 1'b1);
        auto_rts_n = 0;
        #1 check("R10 noshare", rts_out, 1'b0);
        tick();

        // constrained random
        for (int i = 0; i < 4000; i++) begin
            if (i % 250 == 0) begin
                rs485_en = $urandom_range(0, 1);
                fifo_en = ($urandom_range(0, 3) != 0);
                dir_active_low = $urandom_range(0, 1);
                dir_on_rts = $urandom_range(0, 1);
                trig_level = CW'($urandom_range(0, 6));
            end
            case ($urandom_range(0, 3))
                0: tx_count = '0;
                1: if (tx_count != '0) tx_count = tx_count - 1'b1;
                2: if (tx_count < 12) tx_count = tx_count + 1'b1;
                default: ;
            endcase
            if (!fifo_en && tx_count > 1) tx_count = 1;
            if ($urandom_range(0, 2) == 0) ser_busy = ~ser_busy;
            auto_rts_n = $urandom_range(0, 1);
            irq_en = ($urandom_range(0, 15) != 0);
            host_wr = ($urandom_range(0, 7) == 0);
            id_rd = ($urandom_range(0, 7) == 0);
            id_tx_src = $urandom_range(0, 1);
            tick();
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule